// File: doc/BRIEF.md
# Segmented paged address translator

This block turns a virtual address into a physical address for one requester at a time. The top address bits choose one of a small bank of on-chip segment registers. Each register holds the physical base of that segment's page-descriptor array, a limit, and read and write permission bits. The middle bits of the address select a descriptor in that array, and the low bits pass through unchanged as the in-page offset. The descriptor is fetched over a dedicated descriptor-memory port that uses a request/valid handshake.

Segments grow only upwards from an implicit base of zero. A bounds check therefore compares the in-segment part of the address against the limit, and no base has to be subtracted. Once a descriptor is read, the block checks its present bit and its page-level write-deny bit. It then sets the accessed (read) or dirty (write) flag as needed and writes the changed descriptor back. Pages that carry a trap-on-first-access flag raise a trap code when one of those flags first turns on, which is what copy-on-write needs. Segment registers are loaded through a simple write-only configuration port.

Top module: `segxlat`

## Requirements
- R1: Address bits [31:28] select the segment, bits [27:12] form the page number and bits [11:0] the offset. The first descriptor-port access of a translation is a read (dm_we_o=0) at segment base + page×4.
- R2: If va[27:0] is greater than the segment limit, the block finishes with fault code 1 (segment violation) and issues no descriptor access. A value equal to the limit is accepted.
- R3: A load to a segment whose read-permit bit is 0, or a store to one whose write-permit bit is 0, finishes with fault code 3 (permission) and issues no descriptor access.
- R4: If descriptor bit 8 (present) is 0, the block finishes with fault code 2 (not present) and never writes that descriptor back.
- R5: A successful translation gives fault code 0 and pa_o = {descriptor[31:12], va[11:0]}.
- R6: A load sets descriptor bit 9 (read) and a store sets bit 10 (write). The block writes the updated descriptor back to the same address only when that bit was 0 before.
- R7: If descriptor bit 11 (trap-on-first-access) is set and the read or write bit goes from 0 to 1, the write-back still happens and the block finishes with fault code 4 (trap). A repeat access with the bit already set gives no trap and no write-back.
- R8: A store to a page whose descriptor bit 0 (write-deny) is set finishes with fault code 3, whatever the segment's permits. The block does not write that descriptor back.
- R9: done_o is a pulse of one cycle. Whenever fault_o is not 0 at done, pa_o is 0.
- R10: While dm_req_o is high and dm_valid_i has not arrived, dm_req_o stays high and dm_addr_o, dm_we_o and dm_wdata_o stay stable.
- R11: After reset, done_o and dm_req_o are 0. Every segment register holds base 0, limit 0 and both permits cleared.
- R12: A configuration write to a segment register is used by the next translation that selects that segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Segment register write strobe |
| cfg_idx_i | input | 4 | Segment register index |
| cfg_base_i | input | 32 | Descriptor array physical base |
| cfg_limit_i | input | 28 | Highest valid in-segment address |
| cfg_rd_ok_i | input | 1 | Segment read permit |
| cfg_wr_ok_i | input | 1 | Segment write permit |
| req_i | input | 1 | Translation request, held until done |
| va_i | input | 32 | Virtual address |
| store_i | input | 1 | 1 = store access, 0 = load |
| done_o | output | 1 | Result pulse |
| pa_o | output | 32 | Physical address (0 on fault) |
| fault_o | output | 3 | 0 none, 1 segment, 2 not present, 3 permission, 4 trap |
| dm_req_o | output | 1 | Descriptor port request |
| dm_we_o | output | 1 | Descriptor port write |
| dm_addr_o | output | 32 | Descriptor address |
| dm_wdata_o | output | 32 | Updated descriptor |
| dm_valid_i | input | 1 | Descriptor port completion |
| dm_rdata_i | input | 32 | Descriptor read data |

## Verification
The hardest case to reach is the trap on first access, because it depends on descriptor history. The page must be present, carry the trap flag and have the relevant flag still clear. The trap then fires exactly once, and only the next access shows whether the written-back value was used. The stimulus sends a load, a second load and then a store to the same trap page, keeping a backing memory that takes the block's own write-backs. The responder varies its valid latency so that the handshake sits stalled during both fetch and write-back.

// File: rtl/segxlat_pkg.sv
package segxlat_pkg;
  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_SEG    = 3'd1,
    FLT_ABSENT = 3'd2,
    FLT_PERM   = 3'd3,
    FLT_TRAP   = 3'd4
  } fault_e;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WB, ST_RESP} state_e;

  // descriptor flag positions (below the page-base field)
  localparam int unsigned DB_NOWR    = 0;
  localparam int unsigned DB_PRESENT = 8;
  localparam int unsigned DB_READ    = 9;
  localparam int unsigned DB_WRITE   = 10;
  localparam int unsigned DB_INIT    = 11;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int unsigned SEG_W = 4,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned LIM_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEG_W-1:0] widx_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic             rd_ok_i,
  input  logic             wr_ok_i,
  input  logic [SEG_W-1:0] sel_i,
  output logic [PA_W-1:0]  base_o,
  output logic [LIM_W-1:0] limit_o,
  output logic             rd_ok_o,
  output logic             wr_ok_o
);
  localparam int unsigned NSEG = 1 << SEG_W;

  logic [PA_W-1:0]  base_q  [NSEG];
  logic [LIM_W-1:0] limit_q [NSEG];
  logic [NSEG-1:0]  rd_q, wr_q;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
        rd_q[g]    <= 1'b0;
        wr_q[g]    <= 1'b0;
      end else if (we_i && widx_i == SEG_W'(g)) begin
        base_q[g]  <= base_i;
        limit_q[g] <= limit_i;
        rd_q[g]    <= rd_ok_i;
        wr_q[g]    <= wr_ok_i;
      end
    end
  end

  assign base_o  = base_q[sel_i];
  assign limit_o = limit_q[sel_i];
  assign rd_ok_o = rd_q[sel_i];
  assign wr_ok_o = wr_q[sel_i];
endmodule

// File: rtl/desc_eval.sv
module desc_eval
  import segxlat_pkg::*;
#(
  parameter int unsigned DESC_W = 32
) (
  input  logic [DESC_W-1:0] desc_i,
  input  logic              store_i,
  output logic              absent_o,
  output logic              deny_o,
  output logic              upd_o,
  output logic              trap_o,
  output logic [DESC_W-1:0] new_desc_o
);
  logic flag_now;

  assign absent_o = !desc_i[DB_PRESENT];
  assign deny_o   = store_i && desc_i[DB_NOWR];
  assign flag_now = store_i ? desc_i[DB_WRITE] : desc_i[DB_READ];
  assign upd_o    = !flag_now;
  assign trap_o   = upd_o && desc_i[DB_INIT];

  always_comb begin
    new_desc_o = desc_i;
    if (store_i) new_desc_o[DB_WRITE] = 1'b1;
    else         new_desc_o[DB_READ]  = 1'b1;
  end
endmodule

// File: rtl/segxlat.sv
module segxlat
  import segxlat_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned SEG_W  = 4,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned DESC_W = 32,
  localparam int unsigned LIM_W = VA_W - SEG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SEG_W-1:0]  cfg_idx_i,
  input  logic [PA_W-1:0]   cfg_base_i,
  input  logic [LIM_W-1:0]  cfg_limit_i,
  input  logic              cfg_rd_ok_i,
  input  logic              cfg_wr_ok_i,
  input  logic              req_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic              store_i,
  output logic              done_o,
  output logic [PA_W-1:0]   pa_o,
  output logic [2:0]        fault_o,
  output logic              dm_req_o,
  output logic              dm_we_o,
  output logic [PA_W-1:0]   dm_addr_o,
  output logic [DESC_W-1:0] dm_wdata_o,
  input  logic              dm_valid_i,
  input  logic [DESC_W-1:0] dm_rdata_i
);
  localparam int unsigned PG_W   = VA_W - SEG_W - OFF_W;
  localparam int unsigned DESC_B = DESC_W / 8;

  state_e            state_q;
  logic [VA_W-1:0]   va_q;
  logic              store_q;
  logic [PA_W-1:0]   daddr_q;
  logic [DESC_W-1:0] wdata_q;
  fault_e            fault_q;
  logic [PA_W-1:0]   pa_q;

  logic [SEG_W-1:0]  seg_sel;
  logic [PG_W-1:0]   page;
  logic [PA_W-1:0]   seg_base;
  logic [LIM_W-1:0]  seg_limit;
  logic              seg_rd_ok, seg_wr_ok;
  logic              over_limit, seg_deny;
  logic [PA_W-1:0]   desc_addr;

  assign seg_sel = va_i[VA_W-1 -: SEG_W];
  assign page    = va_i[OFF_W +: PG_W];

  seg_regfile #(.SEG_W(SEG_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_segs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .widx_i  (cfg_idx_i),
    .base_i  (cfg_base_i),
    .limit_i (cfg_limit_i),
    .rd_ok_i (cfg_rd_ok_i),
    .wr_ok_i (cfg_wr_ok_i),
    .sel_i   (seg_sel),
    .base_o  (seg_base),
    .limit_o (seg_limit),
    .rd_ok_o (seg_rd_ok),
    .wr_ok_o (seg_wr_ok)
  );

  // limit test runs alongside the descriptor address computation
  assign over_limit = va_i[LIM_W-1:0] > seg_limit;
  assign seg_deny   = store_i ? !seg_wr_ok : !seg_rd_ok;
  assign desc_addr  = seg_base + PA_W'(page) * PA_W'(DESC_B);

  logic              d_absent, d_deny, d_upd, d_trap;
  logic [DESC_W-1:0] d_new;
  logic [PA_W-1:0]   d_pa;

  desc_eval #(.DESC_W(DESC_W)) u_eval (
    .desc_i     (dm_rdata_i),
    .store_i    (store_q),
    .absent_o   (d_absent),
    .deny_o     (d_deny),
    .upd_o      (d_upd),
    .trap_o     (d_trap),
    .new_desc_o (d_new)
  );

  // page base has zero low bits: concatenate, no add
  assign d_pa = PA_W'({dm_rdata_i[DESC_W-1:OFF_W], va_q[OFF_W-1:0]});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      store_q <= 1'b0;
      daddr_q <= '0;
      wdata_q <= '0;
      fault_q <= FLT_NONE;
      pa_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          va_q    <= va_i;
          store_q <= store_i;
          daddr_q <= desc_addr;
          if (over_limit) begin
            fault_q <= FLT_SEG;
            state_q <= ST_RESP;
          end else if (seg_deny) begin
            fault_q <= FLT_PERM;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: if (dm_valid_i) begin
          if (d_absent) begin
            fault_q <= FLT_ABSENT;
            state_q <= ST_RESP;
          end else if (d_deny) begin
            fault_q <= FLT_PERM;
            state_q <= ST_RESP;
          end else if (d_upd) begin
            wdata_q <= d_new;
            fault_q <= d_trap ? FLT_TRAP : FLT_NONE;
            pa_q    <= d_trap ? '0 : d_pa;
            state_q <= ST_WB;
          end else begin
            fault_q <= FLT_NONE;
            pa_q    <= d_pa;
            state_q <= ST_RESP;
          end
        end
        ST_WB: if (dm_valid_i) state_q <= ST_RESP;
        ST_RESP: begin
          fault_q <= FLT_NONE;
          pa_q    <= '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o     = state_q == ST_RESP;
  assign pa_o       = pa_q;
  assign fault_o    = fault_q;
  assign dm_req_o   = state_q == ST_FETCH || state_q == ST_WB;
  assign dm_we_o    = state_q == ST_WB;
  assign dm_addr_o  = daddr_q;
  assign dm_wdata_o = wdata_q;
endmodule

// File: rtl/segxlat_chk.sv
module segxlat_chk
  import segxlat_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned DESC_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [VA_W-1:0]   va_i,
  input logic              done_o,
  input logic [PA_W-1:0]   pa_o,
  input logic [2:0]        fault_o,
  input logic              dm_req_o,
  input logic              dm_we_o,
  input logic [PA_W-1:0]   dm_addr_o,
  input logic [DESC_W-1:0] dm_wdata_o,
  input logic              dm_valid_i
);
  assert_first_is_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dm_req_o) |-> !dm_we_o);

  assert_no_absent_wb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_req_o && dm_we_o |-> dm_wdata_o[DB_PRESENT]);

  assert_offset_passes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && req_i && fault_o == FLT_NONE |-> pa_o[OFF_W-1:0] == va_i[OFF_W-1:0]);

  assert_wb_sets_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_req_o && dm_we_o |-> (dm_wdata_o[DB_READ] || dm_wdata_o[DB_WRITE]));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_fault_zero_pa_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o != FLT_NONE |-> pa_o == '0);

  assert_code_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> fault_o <= 3'd4);

  assert_hold_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_req_o && !dm_valid_i |=> dm_req_o && $stable(dm_addr_o) && $stable(dm_we_o)
      && $stable(dm_wdata_o));

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && dm_req_o));
endmodule

bind segxlat segxlat_chk #(
  .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .DESC_W(DESC_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .va_i       (va_i),
  .done_o     (done_o),
  .pa_o       (pa_o),
  .fault_o    (fault_o),
  .dm_req_o   (dm_req_o),
  .dm_we_o    (dm_we_o),
  .dm_addr_o  (dm_addr_o),
  .dm_wdata_o (dm_wdata_o),
  .dm_valid_i (dm_valid_i)
);

// File: tb/segxlat_tb.sv
module segxlat_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_base = '0;
  logic [27:0] cfg_limit = '0;
  logic        cfg_rd = 1'b0, cfg_wr = 1'b0;
  logic        req = 1'b0;
  logic [31:0] va = '0;
  logic        store = 1'b0;
  logic        done;
  logic [31:0] pa;
  logic [2:0]  fault;
  logic        dm_req, dm_we, dm_valid = 1'b0;
  logic [31:0] dm_addr, dm_wdata, dm_rdata = '0;

  always #2.5 clk = ~clk;

  segxlat u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_base_i(cfg_base),
    .cfg_limit_i(cfg_limit), .cfg_rd_ok_i(cfg_rd), .cfg_wr_ok_i(cfg_wr),
    .req_i(req), .va_i(va), .store_i(store),
    .done_o(done), .pa_o(pa), .fault_o(fault),
    .dm_req_o(dm_req), .dm_we_o(dm_we), .dm_addr_o(dm_addr),
    .dm_wdata_o(dm_wdata), .dm_valid_i(dm_valid), .dm_rdata_i(dm_rdata)
  );

  typedef struct {
    logic [2:0]  flt;
    logic [31:0] pa;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] mem [logic [31:0]];
  logic [31:0] sh_base [16];
  logic [27:0] sh_lim [16];
  logic        sh_rd [16], sh_wr [16];
  int          errors = 0, checks = 0;
  int          rd_cnt = 0, wr_cnt = 0, dly = 0;
  logic [31:0] last_rd_addr = '0;
  int          cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // descriptor memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (dm_req) begin
        repeat (dly % 3) @(negedge clk);
        dly++;
        dm_rdata = mem.exists(dm_addr) ? mem[dm_addr] : 32'h0;
        if (dm_we) begin
          mem[dm_addr] = dm_wdata;
          wr_cnt++;
        end else begin
          last_rd_addr = dm_addr;
          rd_cnt++;
        end
        dm_valid = 1'b1;
        @(negedge clk);
        dm_valid = 1'b0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected done", 32'(fault), 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(fault == e.flt, {e.tag, " fault"}, 32'(fault), 32'(e.flt));
        chk(pa == e.pa, {e.tag, " pa"}, pa, e.pa);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic cfg(input int idx, input logic [31:0] b, input logic [27:0] l, input bit r, input bit w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_base = b; cfg_limit = l; cfg_rd = r; cfg_wr = w;
    @(negedge clk);
    cfg_we = 1'b0;
    sh_base[idx] = b; sh_lim[idx] = l; sh_rd[idx] = r; sh_wr[idx] = w;
  endtask

  task automatic xlate(input logic [31:0] v, input bit st, input string tag);
    exp_t        e;
    int          s, n_rd, n_wr, fl;
    logic [31:0] a, d, nd;
    bit          flag;
    s = int'(v[31:28]);
    a = sh_base[s] + {14'h0, v[27:12], 2'b00};
    d = mem.exists(a) ? mem[a] : 32'h0;
    nd = d; n_rd = 0; n_wr = 0;
    e.pa = 32'h0; e.tag = tag;
    if (v[27:0] > sh_lim[s]) fl = 1;
    else if (st ? !sh_wr[s] : !sh_rd[s]) fl = 3;
    else begin
      n_rd = 1;
      flag = st ? d[10] : d[9];
      if (!d[8]) fl = 2;
      else if (st && d[0]) fl = 3;
      else if (flag) begin
        fl = 0; e.pa = {d[31:12], v[11:0]};
      end else begin
        n_wr = 1;
        nd = d | (st ? 32'h400 : 32'h200);
        if (d[11]) fl = 4;
        else begin fl = 0; e.pa = {d[31:12], v[11:0]}; end
      end
    end
    e.flt = 3'(fl);
    exp_q.push_back(e);
    rd_cnt = 0; wr_cnt = 0;
    @(negedge clk);
    req = 1'b1; va = v; store = st;
    do @(negedge clk); while (!done);
    req = 1'b0;
    @(negedge clk);
    chk(!done, {tag, " R9 done one cycle"}, 32'(done), 32'h0);
    chk(rd_cnt == n_rd, {tag, " fetch count"}, 32'(rd_cnt), 32'(n_rd));
    chk(wr_cnt == n_wr, {tag, " writeback count"}, 32'(wr_cnt), 32'(n_wr));
    if (n_rd == 1) begin
      chk(last_rd_addr == a, {tag, " R1 descriptor address"}, last_rd_addr, a);
      chk(mem[a] == nd, {tag, " R6 stored descriptor"}, mem[a], nd);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      sh_base[i] = '0; sh_lim[i] = '0; sh_rd[i] = 1'b0; sh_wr[i] = 1'b0;
    end
    mem[32'h1000] = 32'h0008_0100; // seg1 page0 present
    mem[32'h1004] = 32'h0009_0000; // seg1 page1 absent
    mem[32'h1008] = 32'h000A_0900; // seg1 page2 trap-on-first-access
    mem[32'h100C] = 32'h000B_0101; // seg1 page3 write-deny
    mem[32'h4008] = 32'h000C_0100; // seg2 page2
    mem[32'h0000] = 32'h000D_0100; // seg5 page0 (unconfigured)
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!done, "R11 done after reset", 32'(done), 32'h0);
    chk(!dm_req, "R11 dm_req after reset", 32'(dm_req), 32'h0);
    xlate(32'h5000_0000, 1'b0, "R11 reset perms");

    cfg(1, 32'h1000, 28'h0FF_FFFF, 1'b1, 1'b1);
    cfg(2, 32'h4000, 28'h000_2FFF, 1'b1, 1'b0);
    cfg(3, 32'h8000, 28'hFFF_FFFF, 1'b0, 1'b0);

    xlate(32'h1000_0ABC, 1'b0, "R5 R6 first load");
    xlate(32'h1000_0123, 1'b0, "R6 repeat load no wb");
    xlate(32'h1000_0FFF, 1'b1, "R6 first store");
    xlate(32'h1000_0004, 1'b1, "R6 repeat store");
    xlate(32'h1000_1000, 1'b0, "R4 not present");
    xlate(32'h1000_1010, 1'b1, "R4 not present store");
    xlate(32'h1000_2040, 1'b0, "R7 trap on first read");
    xlate(32'h1000_2044, 1'b0, "R7 no trap repeat");
    xlate(32'h1000_2048, 1'b1, "R7 trap on first write");
    xlate(32'h1000_3000, 1'b1, "R8 page deny store");
    xlate(32'h1000_3000, 1'b0, "R8 page deny load ok");
    xlate(32'h2000_2FFF, 1'b0, "R2 at limit");
    xlate(32'h2000_3000, 1'b0, "R2 over limit");
    xlate(32'h1100_0000, 1'b0, "R2 seg1 over limit");
    xlate(32'h2000_2000, 1'b1, "R3 seg store denied");
    xlate(32'h3000_0000, 1'b0, "R3 seg load denied");
    cfg(2, 32'h4000, 28'h000_2FFF, 1'b1, 1'b1);
    xlate(32'h2000_2ABC, 1'b1, "R12 new permit used");
    cfg(2, 32'h4000, 28'h000_1FFF, 1'b1, 1'b1);
    xlate(32'h2000_2ABC, 1'b0, "R12 new limit used");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9 scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule